// File: doc/BRIEF.md
# Reconfigurable Single/Dual-Scan Display Line Buffer

This block buffers display words between a DMA read engine and the pixel datapath of a display controller. One 512-word store is used in either of two run-time layouts. In single-scan mode the whole store is one first-in first-out queue. In dual-scan mode it is split into two independent 256-word queues, one per panel half. Each half has its own write target, its own occupancy and its own DMA request.

The DMA side pushes one 32-bit word per cycle. In dual-scan mode a select input steers each word to the upper or the lower queue. The timing generator pulls data with a data-request strobe. The head words are always visible on the read outputs. A request pops one word, or in dual-scan mode one word from each queue together.

A programmable low-water threshold drives a level DMA request for each active queue. Sticky overflow and underflow flags record dropped writes and refused reads. Software clears each flag with a one-cycle clear pulse.

Top module: `scan_fifo_top`

## Requirements
- R1: With `dualScan`=0 the block is one FIFO of 512 words. `cntUp` counts its words, and `rdDataUp` shows the oldest word whenever `rdValid`=1. Words leave in the order they were written. `rdDataLo` reads 0 and `cntLo` stays 0.
- R2: With `dualScan`=1 there are two FIFOs of 256 words each. `wrSel`=0 writes the upper one (`cntUp`, `rdDataUp`) and `wrSel`=1 writes the lower one (`cntLo`, `rdDataLo`).
- R3: In dual-scan mode `rdValid`=1 only when both FIFOs hold at least one word. A `dataReq` then pops one word from each FIFO in the same cycle.
- R4: `dmaReqUp` is 1 while `cntUp` < `threshold`. `dmaReqLo` is 1 while dual-scan is active and `cntLo` < `threshold`. `dmaReqLo` is 0 in single-scan mode. Both requests are levels computed from the registered counts.
- R5: A write to a full target FIFO is dropped: the count and the stored data are unchanged, and `ovfFlag` becomes 1 on the next cycle. `ovfFlag` holds until an `ovfClr` pulse. If a new overflow and `ovfClr` occur in the same cycle, the flag stays 1.
- R6: A `dataReq` while `rdValid`=0 pops nothing, and `udfFlag` becomes 1 on the next cycle. `udfFlag` is sticky and is cleared by `udfClr`, with a new underflow taking priority over the clear.
- R7: A change of `dualScan` empties both FIFOs on the next edge and resets the pointers. Any write or read presented in that same cycle is ignored. Both flags keep their values.
- R8: After reset the block is in single-scan mode with both counts 0, `rdValid`=0 and both flags 0.
- R9: A write and a read to the same FIFO in the same cycle leave its count unchanged. Both operations take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dualScan | input | 1 | 1 = two half-size FIFOs, 0 = one full-size FIFO |
| wrValid | input | 1 | Write strobe from the DMA engine |
| wrSel | input | 1 | Dual-scan write target: 0 upper, 1 lower |
| wrData | input | 32 | Word to write |
| dataReq | input | 1 | Pop request from the timing generator |
| threshold | input | 10 | Low-water level for DMA requests |
| ovfClr | input | 1 | Pulse to clear the overflow flag |
| udfClr | input | 1 | Pulse to clear the underflow flag |
| rdValid | output | 1 | Head word(s) available |
| rdDataUp | output | 32 | Head of the single or upper FIFO |
| rdDataLo | output | 32 | Head of the lower FIFO (0 in single-scan) |
| cntUp | output | 10 | Occupancy of the single or upper FIFO |
| cntLo | output | 10 | Occupancy of the lower FIFO |
| dmaReqUp | output | 1 | DMA request for the single or upper FIFO |
| dmaReqLo | output | 1 | DMA request for the lower FIFO |
| ovfFlag | output | 1 | Sticky overflow |
| udfFlag | output | 1 | Sticky underflow |

## Verification
The bench fills the single queue to exactly 512 words and probes the request at the threshold boundary. A design with an off-by-one compare or a 256-word limit in single-scan mode would show the wrong count or the wrong request level there. It then writes into the full queue and drains it in order; a design that stored the dropped word or advanced a pointer anyway would return data out of order.

In dual-scan mode the bench starves one half. A design that popped only one queue, or checked only one queue for emptiness, would corrupt the other count and miss the underflow. Other checks cover a mode change that arrives together with a write, and a clear pulse that coincides with a new overflow. These catch designs that let the write through, that lose the flags on a mode change, or that give the clear priority over a new error.

// File: rtl/scan_fifo_pkg.sv
package scan_fifo_pkg;
  typedef struct packed {
    logic dual;
    logic clear;
    logic wrEn;
    logic wrLower;
    logic pop;
  } fifo_strb_t;
endpackage

// File: rtl/scan_fifo_data.sv
module scan_fifo_data
  import scan_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_strb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataUp,
  output logic [DATA_W-1:0] rdDataLo
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = AW - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wpA, rpA, wpB, rpB;
  logic [AW-1:0] wrAddr, rdAddrB;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic dual);
    if (dual) bump = {1'b0, p[HW-1:0] + 1'b1};
    else      bump = p + 1'b1;
  endfunction

  assign rdAddrB = {1'b1, rpB[HW-1:0]};
  assign wrAddr  = strb.wrLower ? {1'b1, wpB[HW-1:0]} : wpA;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wpA <= '0; rpA <= '0; wpB <= '0; rpB <= '0;
    end else begin
      if (strb.wrEn && !strb.wrLower) wpA <= bump(wpA, strb.dual);
      if (strb.wrEn && strb.wrLower)  wpB <= bump(wpB, 1'b1);
      if (strb.pop) rpA <= bump(rpA, strb.dual);
      if (strb.pop && strb.dual) rpB <= bump(rpB, 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= wrData;
  end

  assign rdDataUp = mem[rpA];
  assign rdDataLo = strb.dual ? mem[rdAddrB] : '0;

  // R2
  half_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dual |-> (!wpA[HW] && !rpA[HW]));
endmodule

// File: rtl/scan_fifo_ctrl.sv
module scan_fifo_ctrl
  import scan_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dualScan,
  input  logic             wrValid,
  input  logic             wrSel,
  input  logic             dataReq,
  input  logic [CNT_W-1:0] threshold,
  input  logic             ovfClr,
  input  logic             udfClr,
  output fifo_strb_t       strb,
  output logic [CNT_W-1:0] cntUp,
  output logic [CNT_W-1:0] cntLo,
  output logic             rdValid,
  output logic             dmaReqUp,
  output logic             dmaReqLo,
  output logic             ovfFlag,
  output logic             udfFlag
);
  localparam int HALF = DEPTH / 2;

  logic modeQ, modeChg, tgtLower, tgtFull, fullUp, fullLo;
  logic wrOk, wrBad, popOk, rdBad;
  logic [CNT_W-1:0] capUp;

  assign capUp    = modeQ ? CNT_W'(HALF) : CNT_W'(DEPTH);
  assign fullUp   = (cntUp == capUp);
  assign fullLo   = (cntLo == CNT_W'(HALF));
  assign modeChg  = (dualScan != modeQ);
  assign tgtLower = modeQ && wrSel;
  assign tgtFull  = tgtLower ? fullLo : fullUp;
  assign rdValid  = modeQ ? (cntUp != '0 && cntLo != '0) : (cntUp != '0);

  assign wrOk  = !modeChg && wrValid && !tgtFull;
  assign wrBad = !modeChg && wrValid && tgtFull;
  assign popOk = !modeChg && dataReq && rdValid;
  assign rdBad = !modeChg && dataReq && !rdValid;

  always_comb begin
    strb.dual    = modeQ;
    strb.clear   = modeChg;
    strb.wrEn    = wrOk;
    strb.wrLower = tgtLower;
    strb.pop     = popOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      cntUp   <= '0;
      cntLo   <= '0;
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
    end else begin
      modeQ <= dualScan;
      if (modeChg) begin
        cntUp <= '0;
        cntLo <= '0;
      end else begin
        cntUp <= cntUp + CNT_W'(wrOk && !tgtLower) - CNT_W'(popOk);
        cntLo <= cntLo + CNT_W'(wrOk && tgtLower) - CNT_W'(popOk && modeQ);
      end
      ovfFlag <= wrBad || (ovfFlag && !ovfClr);
      udfFlag <= rdBad || (udfFlag && !udfClr);
    end
  end

  assign dmaReqUp = (cntUp < threshold);
  assign dmaReqLo = modeQ && (cntLo < threshold);

  // R1 R2
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntUp <= capUp) && (cntLo <= CNT_W'(HALF)));
  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !tgtLower && fullUp) |=> (cntUp <= $past(cntUp)));
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrBad |=> ovfFlag);
  // R6
  udf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdBad |=> udfFlag);
  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (cntUp == '0 && cntLo == '0));
  // R3
  dual_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popOk && modeQ && !wrValid) |=> (cntLo == $past(cntLo) - 1'b1));
endmodule

// File: rtl/scan_fifo_top.sv
module scan_fifo_top
  import scan_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dualScan,
  input  logic              wrValid,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataReq,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              ovfClr,
  input  logic              udfClr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdDataUp,
  output logic [DATA_W-1:0] rdDataLo,
  output logic [CNT_W-1:0]  cntUp,
  output logic [CNT_W-1:0]  cntLo,
  output logic              dmaReqUp,
  output logic              dmaReqLo,
  output logic              ovfFlag,
  output logic              udfFlag
);
  fifo_strb_t strb;

  scan_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dualScan(dualScan), .wrValid(wrValid),
    .wrSel(wrSel), .dataReq(dataReq), .threshold(threshold),
    .ovfClr(ovfClr), .udfClr(udfClr), .strb(strb), .cntUp(cntUp),
    .cntLo(cntLo), .rdValid(rdValid), .dmaReqUp(dmaReqUp),
    .dmaReqLo(dmaReqLo), .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  scan_fifo_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdDataUp(rdDataUp), .rdDataLo(rdDataLo)
  );
endmodule

// File: tb/scan_fifo_top_tb.sv
module scan_fifo_top_tb;
  logic clk = 1'b0;
  logic rstN, dualScan, wrValid, wrSel, dataReq, ovfClr, udfClr;
  logic [31:0] wrData;
  logic [9:0] threshold;
  logic rdValid, dmaReqUp, dmaReqLo, ovfFlag, udfFlag;
  logic [31:0] rdDataUp, rdDataLo;
  logic [9:0] cntUp, cntLo;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scan_fifo_top u_dut (
    .clk(clk), .rstN(rstN), .dualScan(dualScan), .wrValid(wrValid),
    .wrSel(wrSel), .wrData(wrData), .dataReq(dataReq), .threshold(threshold),
    .ovfClr(ovfClr), .udfClr(udfClr), .rdValid(rdValid), .rdDataUp(rdDataUp),
    .rdDataLo(rdDataLo), .cntUp(cntUp), .cntLo(cntLo), .dmaReqUp(dmaReqUp),
    .dmaReqLo(dmaReqLo), .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  // {wr, rd, data[7:0], expCnt[9:0], expValid, expHead[7:0]}
  localparam logic [28:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA1, 10'd1, 1'b1, 8'hA1},
    {1'b1, 1'b0, 8'hB2, 10'd2, 1'b1, 8'hA1},
    {1'b1, 1'b1, 8'hC3, 10'd2, 1'b1, 8'hB2},
    {1'b0, 1'b1, 8'h00, 10'd1, 1'b1, 8'hC3},
    {1'b0, 1'b1, 8'h00, 10'd0, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h00, 10'd0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'hD4, 10'd1, 1'b1, 8'hD4},
    {1'b1, 1'b0, 8'hE5, 10'd2, 1'b1, 8'hD4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wv, input logic ws, input logic [31:0] wd, input logic rq);
    wrValid = wv; wrSel = ws; wrData = wd; dataReq = rq;
    @(negedge clk);
    wrValid = 0; dataReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; dualScan = 0; wrValid = 0; wrSel = 0; wrData = 0; dataReq = 0;
    ovfClr = 0; udfClr = 0; threshold = 10'd4;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 cntUp", cntUp, 0);
    chk("R8 cntLo", cntLo, 0);
    chk("R8 rdValid", rdValid, 0);
    chk("R8 ovf", ovfFlag, 0);
    chk("R8 udf", udfFlag, 0);
    chk("R4 reqUp", dmaReqUp, 1);
    chk("R4 reqLo single", dmaReqLo, 0);

    // R1 R9 R4 table
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][28], 1'b0, {24'h0, VEC[i][26:19]}, VEC[i][27]);
      chk("R1 R9 count", cntUp, {22'h0, VEC[i][18:9]});
      chk("R1 valid", rdValid, VEC[i][8]);
      if (VEC[i][8]) chk("R1 head", rdDataUp, {24'h0, VEC[i][7:0]});
      chk("R1 lo zero", rdDataLo, 0);
      chk("R4 reqUp", dmaReqUp, VEC[i][18:9] < 10'd4);
    end
    chk("R6 udf set", udfFlag, 1);

    // R7 mode change clears counts, keeps flags
    dualScan = 1; @(negedge clk);
    chk("R7 cleared", cntUp, 0);
    chk("R7 udf kept", udfFlag, 1);
    dualScan = 0; @(negedge clk);
    udfClr = 1; @(negedge clk); udfClr = 0;
    chk("R6 udf clr", udfFlag, 0);

    // R1 full 512 single FIFO, R4 threshold boundary
    threshold = 10'd500;
    for (int i = 0; i < 512; i++) begin
      cyc(1, 0, 32'h1000 + i, 0);
      if (i == 498) chk("R4 req below", dmaReqUp, 1);
      if (i == 499) chk("R4 req at thr", dmaReqUp, 0);
    end
    chk("R1 full count", cntUp, 512);
    chk("R5 no ovf yet", ovfFlag, 0);
    cyc(1, 0, 32'hDEAD, 0);
    chk("R5 ovf", ovfFlag, 1);
    chk("R5 count kept", cntUp, 512);
    ovfClr = 1; cyc(1, 0, 32'hBEEF, 0); ovfClr = 0;
    chk("R5 set wins", ovfFlag, 1);
    ovfClr = 1; @(negedge clk); ovfClr = 0;
    chk("R5 clr", ovfFlag, 0);
    for (int i = 0; i < 512; i++) begin
      if (rdDataUp !== 32'h1000 + i) chk("R1 R5 order", rdDataUp, 32'h1000 + i);
      cyc(0, 0, 0, 1);
    end
    tests++;
    chk("R1 drained", cntUp, 0);

    // R2 R3 dual
    dualScan = 1; @(negedge clk);
    threshold = 10'd1;
    cyc(1, 0, 32'd10, 0);
    cyc(1, 0, 32'd11, 0);
    cyc(1, 0, 32'd12, 0);
    cyc(1, 1, 32'd20, 0);
    chk("R2 cntUp", cntUp, 3);
    chk("R2 cntLo", cntLo, 1);
    chk("R3 valid", rdValid, 1);
    chk("R2 headUp", rdDataUp, 10);
    chk("R2 headLo", rdDataLo, 20);
    chk("R4 reqLo off", dmaReqLo, 0);
    chk("R4 reqUp off", dmaReqUp, 0);
    cyc(0, 0, 0, 1);
    chk("R3 pop up", cntUp, 2);
    chk("R3 pop lo", cntLo, 0);
    chk("R3 not valid", rdValid, 0);
    chk("R4 reqLo on", dmaReqLo, 1);
    chk("R3 next head", rdDataUp, 11);
    cyc(0, 0, 0, 1);
    chk("R6 dual udf", udfFlag, 1);
    chk("R6 up kept", cntUp, 2);
    for (int i = 0; i < 256; i++) cyc(1, 1, 32'h200 + i, 0);
    chk("R2 lo full", cntLo, 256);
    chk("R2 lo head", rdDataLo, 32'h200);
    cyc(1, 1, 32'hFFFF, 0);
    chk("R5 lo ovf", ovfFlag, 1);
    chk("R5 lo kept", cntLo, 256);
    chk("R2 up untouched", cntUp, 2);

    // R7 write in the mode-change cycle is ignored
    dualScan = 0;
    cyc(1, 0, 32'h55, 0);
    chk("R7 up clear", cntUp, 0);
    chk("R7 lo clear", cntLo, 0);
    chk("R7 ovf kept", ovfFlag, 1);
    chk("R4 reqLo single", dmaReqLo, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule